// File: doc/BRIEF.md
# Issue Window Operand Wakeup

This block is a small out-of-order issue window. It tracks the readiness of the instructions waiting in it. Each slot holds one waiting instruction. That instruction has a left and a right source operand, and each operand carries a physical register tag and a ready flag. At every clock edge, up to `IW` producing units may announce a completed result by putting its tag on a broadcast bus. Each slot on the bus carries its own valid bit. Every stored operand tag is compared with all of the broadcast tags at once. Any hit sets that operand's ready flag, and the flag then stays set.

A slot raises its issue request when it is occupied and both of its operands are ready. An external selector, which is not part of this block, chooses among the requests and returns a grant. A granted slot is released at the next edge. The rename stage fills slots through the allocation port. It supplies the two tags, plus a ready flag for each operand whose value already exists. A result broadcast in the same cycle as the allocation is compared against the incoming tags, so that the wakeup is not lost.

Top module: `iq_wakeup`

## Requirements
- R1: While `rst_n` is low at a clock edge, every slot is emptied. After reset, `req` reads all zeros.
- R2: When `alloc_en` is high at an edge, slot `alloc_idx` becomes occupied and holds `alloc_ltag`/`alloc_rtag`. Its ready flags are loaded from `alloc_lrdy`/`alloc_rrdy`. If both flags are 1, its `req` bit is 1 right after that edge.
- R3: An occupied operand whose tag equals a broadcast tag with its valid bit set has its ready flag set at that edge. This applies to the left and to the right operand independently.
- R4: A broadcast slot whose `bc_valid` bit is 0 never sets any ready flag, whatever tag it carries.
- R5: Once set, a ready flag stays set until its slot is allocated again. Idle cycles and unrelated broadcasts do not clear it.
- R6: `req[i]` is 1 exactly when slot i is occupied and both of its ready flags are set. The bit is taken from registered state, so it changes only after a clock edge.
- R7: A `grant[i]` bit seen at an edge empties slot i, so `req[i]` is 0 after that edge. If `alloc_en` targets the same slot in the same cycle, the allocation wins and the slot holds the new instruction.
- R8: A valid broadcast tag that matches `alloc_ltag` or `alloc_rtag` in the allocation cycle marks that operand ready in the newly written slot.
- R9: Broadcast slot k occupies bits `[k*TAG_W +: TAG_W]` of `bc_tags` and is gated by `bc_valid[k]`. Any slot position can wake an operand. Several slots can wake both operands of one entry in the same cycle, and one tag can wake both operands at once.
- R10: Allocating into an occupied slot replaces its tags and ready flags completely, with no memory of the previous instruction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous reset, active low |
| alloc_en | input | 1 | Write one slot this cycle |
| alloc_idx | input | $clog2(ENTRIES) | Slot to write |
| alloc_ltag | input | TAG_W | Left operand tag |
| alloc_lrdy | input | 1 | Left operand already available |
| alloc_rtag | input | TAG_W | Right operand tag |
| alloc_rrdy | input | 1 | Right operand already available |
| bc_valid | input | IW | Per-slot valid bit for the result broadcast |
| bc_tags | input | IW*TAG_W | Broadcast result tags, slot k at bits k*TAG_W |
| grant | input | ENTRIES | Selected slots, released at the next edge |
| req | output | ENTRIES | Per-slot issue request |

## Verification
Every result appears one edge after the stimulus that causes it. Allocation, a broadcast, or a grant presented before edge t shows on `req` once edge t has passed, and `req` carries no combinational path from any input. The bench drives inputs on the falling edge. Its reference model computes the next state from the same inputs, and after the following rising edge it compares all request bits at the next falling edge. One directed section covers each requirement's corner cases, including an allocation that collides with a grant and a broadcast that coincides with the allocation. A long pseudo-random section then mixes all three inputs.

// File: rtl/iq_wakeup_pkg.sv
// Package: iq_wakeup_pkg
// Holds the default sizing shared by the wakeup window modules.
// Assumes every user takes these values as defaults and may override them.
package iq_wakeup_pkg;
    localparam int unsigned DEF_ENTRIES = 16;
    localparam int unsigned DEF_TAG_W   = 6;
    localparam int unsigned DEF_IW      = 4;
endpackage

// File: rtl/iq_tag_match.sv
// Module: iq_tag_match
// Compares one operand tag with every slot of the result broadcast at once,
// and ORs the per-slot equalities into a single hit.
// Assumes bc_tags_i packs slot k at bits [k*TAG_W +: TAG_W]. Slots with a
// clear valid bit are masked off.
module iq_tag_match #(
    parameter int unsigned TAG_W = iq_wakeup_pkg::DEF_TAG_W,
    parameter int unsigned IW    = iq_wakeup_pkg::DEF_IW
) (
    input  logic [TAG_W-1:0]    tag_i,
    input  logic [IW-1:0]       bc_valid_i,
    input  logic [IW*TAG_W-1:0] bc_tags_i,
    output logic                hit_o
);
    logic [IW-1:0] slot_eq;

    // One equality comparator per broadcast slot
    for (genvar k = 0; k < IW; k++) begin : g_slot
        assign slot_eq[k] = bc_valid_i[k] && (bc_tags_i[k*TAG_W +: TAG_W] == tag_i);
    end

    assign hit_o = |slot_eq;
endmodule

// File: rtl/iq_wakeup_entry.sv
// Module: iq_wakeup_entry
// One slot of the issue window. It holds two operand tags with sticky ready
// flags and raises req_o when it is occupied and both flags are set.
// Assumes the parent has already matched the allocation tags against the
// broadcast (alloc_lhit_i/alloc_rhit_i). Allocation takes priority over grant.
module iq_wakeup_entry #(
    parameter int unsigned TAG_W = iq_wakeup_pkg::DEF_TAG_W,
    parameter int unsigned IW    = iq_wakeup_pkg::DEF_IW
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                alloc_i,
    input  logic [TAG_W-1:0]    alloc_ltag_i,
    input  logic                alloc_lrdy_i,
    input  logic                alloc_lhit_i,
    input  logic [TAG_W-1:0]    alloc_rtag_i,
    input  logic                alloc_rrdy_i,
    input  logic                alloc_rhit_i,
    input  logic [IW-1:0]       bc_valid_i,
    input  logic [IW*TAG_W-1:0] bc_tags_i,
    input  logic                grant_i,
    output logic                req_o
);
    logic             valid_q;
    logic [TAG_W-1:0] ltag_q, rtag_q;
    logic             lrdy_q, rrdy_q;
    logic             hit_l, hit_r;

    iq_tag_match #(.TAG_W(TAG_W), .IW(IW)) u_match_l (
        .tag_i      (ltag_q),
        .bc_valid_i (bc_valid_i),
        .bc_tags_i  (bc_tags_i),
        .hit_o      (hit_l)
    );

    iq_tag_match #(.TAG_W(TAG_W), .IW(IW)) u_match_r (
        .tag_i      (rtag_q),
        .bc_valid_i (bc_valid_i),
        .bc_tags_i  (bc_tags_i),
        .hit_o      (hit_r)
    );

    // Slot state: write on allocate, release on grant, otherwise OR in wakeups
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q <= 1'b0;
            ltag_q  <= '0;
            rtag_q  <= '0;
            lrdy_q  <= 1'b0;
            rrdy_q  <= 1'b0;
        end else if (alloc_i) begin
            valid_q <= 1'b1;
            ltag_q  <= alloc_ltag_i;
            rtag_q  <= alloc_rtag_i;
            lrdy_q  <= alloc_lrdy_i | alloc_lhit_i;
            rrdy_q  <= alloc_rrdy_i | alloc_rhit_i;
        end else begin
            if (grant_i) valid_q <= 1'b0;
            lrdy_q <= lrdy_q | hit_l;
            rrdy_q <= rrdy_q | hit_r;
        end
    end

    // Request from registered state only
    assign req_o = valid_q & lrdy_q & rrdy_q;

    p_alloc_ready_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (alloc_i && alloc_lrdy_i && alloc_rrdy_i) |=> req_o);
    p_wake_left_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!alloc_i && hit_l) |=> lrdy_q);
    p_wake_right_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!alloc_i && hit_r) |=> rrdy_q);
    p_no_invalid_wake_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (!alloc_i && bc_valid_i == '0) |=> (lrdy_q == $past(lrdy_q) && rrdy_q == $past(rrdy_q)));
    p_sticky_ready_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!alloc_i && lrdy_q && rrdy_q) |=> (lrdy_q && rrdy_q));
    p_grant_release_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (grant_i && !alloc_i) |=> !req_o);
    p_alloc_wins_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (grant_i && alloc_i) |=> valid_q);
    p_alloc_catch_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (alloc_i && alloc_lhit_i && alloc_rhit_i) |=> req_o);
endmodule

// File: rtl/iq_wakeup.sv
// Module: iq_wakeup
// Issue window wakeup array. It keeps ENTRIES slots, and each slot wakes its
// operands from up to IW result tags per cycle. It exposes one issue request
// per slot.
// Assumes at most one allocation per cycle. The selector that drives grant
// is external.
module iq_wakeup #(
    parameter int unsigned ENTRIES = iq_wakeup_pkg::DEF_ENTRIES,
    parameter int unsigned TAG_W   = iq_wakeup_pkg::DEF_TAG_W,
    parameter int unsigned IW      = iq_wakeup_pkg::DEF_IW,
    localparam int unsigned IDX_W  = (ENTRIES > 1) ? $clog2(ENTRIES) : 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                alloc_en,
    input  logic [IDX_W-1:0]    alloc_idx,
    input  logic [TAG_W-1:0]    alloc_ltag,
    input  logic                alloc_lrdy,
    input  logic [TAG_W-1:0]    alloc_rtag,
    input  logic                alloc_rrdy,
    input  logic [IW-1:0]       bc_valid,
    input  logic [IW*TAG_W-1:0] bc_tags,
    input  logic [ENTRIES-1:0]  grant,
    output logic [ENTRIES-1:0]  req
);
    logic alloc_lhit, alloc_rhit;

    // Shared match of the incoming tags against the same-cycle broadcast
    iq_tag_match #(.TAG_W(TAG_W), .IW(IW)) u_alloc_match_l (
        .tag_i      (alloc_ltag),
        .bc_valid_i (bc_valid),
        .bc_tags_i  (bc_tags),
        .hit_o      (alloc_lhit)
    );

    iq_tag_match #(.TAG_W(TAG_W), .IW(IW)) u_alloc_match_r (
        .tag_i      (alloc_rtag),
        .bc_valid_i (bc_valid),
        .bc_tags_i  (bc_tags),
        .hit_o      (alloc_rhit)
    );

    // One slot per window position, each with its own allocation decode
    for (genvar i = 0; i < ENTRIES; i++) begin : g_entry
        logic sel;
        assign sel = alloc_en && (alloc_idx == IDX_W'(i));

        iq_wakeup_entry #(.TAG_W(TAG_W), .IW(IW)) u_entry (
            .clk          (clk),
            .rst_n        (rst_n),
            .alloc_i      (sel),
            .alloc_ltag_i (alloc_ltag),
            .alloc_lrdy_i (alloc_lrdy),
            .alloc_lhit_i (alloc_lhit),
            .alloc_rtag_i (alloc_rtag),
            .alloc_rrdy_i (alloc_rrdy),
            .alloc_rhit_i (alloc_rhit),
            .bc_valid_i   (bc_valid),
            .bc_tags_i    (bc_tags),
            .grant_i      (grant[i]),
            .req_o        (req[i])
        );
    end

    p_reset_clear_r1: assert property (@(posedge clk)
        !rst_n |=> (req == '0));
endmodule

// File: tb/iq_wakeup_tb.sv
module iq_wakeup_tb;
    localparam int CLK_PERIOD = 10;
    localparam int ENTRIES = 16;
    localparam int TAG_W   = 6;
    localparam int IW      = 4;
    localparam int IDX_W   = $clog2(ENTRIES);

    logic                clk = 1'b0;
    logic                rst_n;
    logic                alloc_en;
    logic [IDX_W-1:0]    alloc_idx;
    logic [TAG_W-1:0]    alloc_ltag, alloc_rtag;
    logic                alloc_lrdy, alloc_rrdy;
    logic [IW-1:0]       bc_valid;
    logic [IW*TAG_W-1:0] bc_tags;
    logic [ENTRIES-1:0]  grant;
    logic [ENTRIES-1:0]  req;

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    // Reference model state
    bit               m_valid [ENTRIES];
    bit [TAG_W-1:0]   m_ltag  [ENTRIES];
    bit [TAG_W-1:0]   m_rtag  [ENTRIES];
    bit               m_lrdy  [ENTRIES];
    bit               m_rrdy  [ENTRIES];

    always #(CLK_PERIOD/2) clk = ~clk;

    iq_wakeup #(.ENTRIES(ENTRIES), .TAG_W(TAG_W), .IW(IW)) u_dut (
        .clk(clk), .rst_n(rst_n), .alloc_en(alloc_en), .alloc_idx(alloc_idx),
        .alloc_ltag(alloc_ltag), .alloc_lrdy(alloc_lrdy),
        .alloc_rtag(alloc_rtag), .alloc_rrdy(alloc_rrdy),
        .bc_valid(bc_valid), .bc_tags(bc_tags), .grant(grant), .req(req)
    );

    function automatic bit seen(input bit [TAG_W-1:0] t);
        for (int k = 0; k < IW; k++)
            if (bc_valid[k] && bc_tags[k*TAG_W +: TAG_W] == t) return 1'b1;
        return 1'b0;
    endfunction

    function automatic bit [ENTRIES-1:0] expected_req();
        bit [ENTRIES-1:0] e;
        for (int i = 0; i < ENTRIES; i++) e[i] = m_valid[i] & m_lrdy[i] & m_rrdy[i];
        return e;
    endfunction

    task automatic quiet();
        alloc_en = 0; alloc_idx = '0; alloc_ltag = '0; alloc_rtag = '0;
        alloc_lrdy = 0; alloc_rrdy = 0; bc_valid = '0; bc_tags = '0; grant = '0;
    endtask

    task automatic put_bc(input int k, input bit v, input bit [TAG_W-1:0] t);
        bc_valid[k] = v;
        bc_tags[k*TAG_W +: TAG_W] = t;
    endtask

    task automatic do_alloc(input int idx, input bit [TAG_W-1:0] lt, input bit lr,
                            input bit [TAG_W-1:0] rt, input bit rr);
        alloc_en = 1; alloc_idx = IDX_W'(idx);
        alloc_ltag = lt; alloc_lrdy = lr; alloc_rtag = rt; alloc_rrdy = rr;
    endtask

    task automatic check_req(input string rq);
        bit [ENTRIES-1:0] e;
        e = expected_req();
        total++;
        if (req !== e) begin
            bad++;
            $display("FAIL %s: req actual=%h expected=%h", rq, req, e);
        end
    endtask

    // One clock: update model from present inputs, pass the edge, compare
    task automatic step(input string rq);
        bit             nv [ENTRIES];
        bit [TAG_W-1:0] nl [ENTRIES];
        bit [TAG_W-1:0] nr [ENTRIES];
        bit             nlr[ENTRIES];
        bit             nrr[ENTRIES];
        for (int i = 0; i < ENTRIES; i++) begin
            nv[i] = m_valid[i]; nl[i] = m_ltag[i]; nr[i] = m_rtag[i];
            nlr[i] = m_lrdy[i]; nrr[i] = m_rrdy[i];
            if (!rst_n) begin
                nv[i] = 0; nlr[i] = 0; nrr[i] = 0;
            end else if (alloc_en && int'(alloc_idx) == i) begin
                nv[i] = 1; nl[i] = alloc_ltag; nr[i] = alloc_rtag;
                nlr[i] = alloc_lrdy | seen(alloc_ltag);
                nrr[i] = alloc_rrdy | seen(alloc_rtag);
            end else begin
                if (grant[i]) nv[i] = 0;
                nlr[i] = m_lrdy[i] | seen(m_ltag[i]);
                nrr[i] = m_rrdy[i] | seen(m_rtag[i]);
            end
        end
        @(posedge clk);
        @(negedge clk);
        for (int i = 0; i < ENTRIES; i++) begin
            m_valid[i] = nv[i]; m_ltag[i] = nl[i]; m_rtag[i] = nr[i];
            m_lrdy[i] = nlr[i]; m_rrdy[i] = nrr[i];
        end
        check_req(rq);
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        quiet();
        rst_n = 0;
        for (int i = 0; i < ENTRIES; i++) begin
            m_valid[i] = 0; m_ltag[i] = 0; m_rtag[i] = 0; m_lrdy[i] = 0; m_rrdy[i] = 0;
        end
        @(negedge clk);
        step("R1"); step("R1");
        rst_n = 1;
        step("R1");

        // R2: allocate an entry whose operands are both pending
        do_alloc(3, 6'd5, 0, 6'd9, 0); step("R2");
        quiet();
        // R3: left operand woken from broadcast slot 2
        put_bc(2, 1, 6'd5); step("R3");
        quiet();
        // R4: matching tag on an invalid slot must not wake
        put_bc(0, 0, 6'd9); put_bc(1, 0, 6'd9); step("R4");
        quiet();
        // R9: right operand woken from the highest slot position
        put_bc(3, 1, 6'd9); step("R9");
        quiet();
        // R5: readiness held over idle cycles and unrelated broadcasts
        step("R5");
        put_bc(0, 1, 6'd40); step("R5");
        quiet();
        // R7: grant releases the slot
        grant[3] = 1; step("R7");
        quiet(); step("R7");
        // R2: allocate with both operands already available
        do_alloc(7, 6'd11, 1, 6'd12, 1); step("R2");
        quiet();
        // R8: wakeup during the allocation cycle is not lost
        do_alloc(1, 6'd20, 0, 6'd21, 0); put_bc(1, 1, 6'd20); put_bc(2, 1, 6'd21); step("R8");
        quiet();
        // R10: overwrite an occupied ready slot with pending operands
        do_alloc(7, 6'd30, 0, 6'd31, 0); step("R10");
        quiet();
        // R7: grant and allocation to the same slot, allocation wins
        grant[1] = 1; do_alloc(1, 6'd2, 1, 6'd3, 1); step("R7");
        quiet();
        // R9: one broadcast tag wakes both operands at once
        do_alloc(5, 6'd44, 0, 6'd44, 0); step("R9");
        quiet(); put_bc(1, 1, 6'd44); step("R9");
        quiet();
        // R9: two different slots wake both operands of slot 7 together
        put_bc(0, 1, 6'd31); put_bc(3, 1, 6'd30); step("R9");
        quiet();
        // R6: request low when only one operand is ready
        do_alloc(9, 6'd50, 1, 6'd51, 0); step("R6");
        quiet(); step("R6");

        // R6: mixed pseudo-random traffic
        for (int n = 0; n < 3000; n++) begin
            bit [ENTRIES-1:0] e;
            quiet();
            e = expected_req();
            if ($urandom_range(0, 2) != 0)
                do_alloc($urandom_range(0, ENTRIES-1), TAG_W'($urandom_range(0, 9)),
                         1'($urandom_range(0, 3) == 0), TAG_W'($urandom_range(0, 9)),
                         1'($urandom_range(0, 3) == 0));
            for (int k = 0; k < IW; k++)
                put_bc(k, 1'($urandom_range(0, 1)), TAG_W'($urandom_range(0, 9)));
            grant = e & ENTRIES'($urandom);
            step("R6");
        end

        quiet();
        rst_n = 0; step("R1");
        rst_n = 1; step("R1");

        done = 1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule